// File: doc/BRIEF.md
# Calendar Timekeeper with Time-of-Day Alarm

This block keeps wall-clock time and the calendar date for a chip. It counts seconds, minutes, hours, weekday, day of the month, month and a two-digit year, and holds a three-field alarm (hours, minutes, seconds). A strobe arriving once per second advances the time by one second. All carries run through the chain: seconds to minutes, minutes to hours, hours to day, day to month, month to year. Software reads and writes every field through a small indexed register port.

Two mode inputs set how the fields are coded and counted. The first picks packed BCD or plain binary. The second picks a 24-hour clock or a 12-hour clock with an afternoon flag. A hold input stops the per-second advance, so software can load a consistent time. Each completed advance gives a one-cycle update pulse. An alarm pulse is given when the newly advanced time matches all three alarm fields. An alarm field whose top two bits are both set matches any value. Both pulses go to a separate interrupt block.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, every field reads 0 except weekday, day of month and month, which read 1. Both event outputs are 0.
- R2: Register indices are: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 weekday, 7 day of month, 8 month, 9 year. A write stores the byte and a read returns it. Indices 10 to 15 read 0, and writes to them change no field.
- R3: With `bin_mode`=0 (packed BCD), seconds and minutes step the low nibble and carry into the high nibble after 9 (0x09→0x10). They wrap 0x59→0x00 and carry into the next field.
- R4: With `bin_mode`=1, fields count in plain binary (9→10, that is 0x0A). Seconds and minutes wrap 59→0 with carry.
- R5: With `hour24`=1, hours wrap 23→0 and carry into weekday and day of month.
- R6: With `hour24`=0, hours hold 1 to 12 in bits 6:0 and bit 7 set means afternoon. 11→12 toggles bit 7. 12→1 keeps bit 7. The day advances only on 11 afternoon → 12 morning (0x91→0x12 in BCD).
- R7: Day of month wraps after the month length: 30 for April, June, September and November. February has 29 when the year is divisible by 4 and 28 otherwise. All other months have 31. Month wraps 12→1 and carries into the year, which wraps 99→0.
- R8: Weekday cycles 1 to 7, then back to 1 on each day carry.
- R9: While `set_hold`=1, a strobe changes no field and gives no update pulse.
- R10: Each strobe taken with `set_hold`=0 and `wr_en`=0 advances the time at that clock edge. `upd_evt` is high for exactly the following cycle.
- R11: `alm_evt` pulses together with `upd_evt` when all three alarm fields match the advanced time. An alarm byte from 0xC0 to 0xFF matches any value of its field.
- R12: A write in the same cycle as a strobe takes priority. The write is stored, that second's advance is dropped, and no event is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle once-per-second advance strobe |
| set_hold | input | 1 | Suppresses the advance while 1 |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| hour24 | input | 1 | 1 = 24-hour clock, 0 = 12-hour with bit 7 afternoon |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| upd_evt | output | 1 | One-cycle pulse after each advance |
| alm_evt | output | 1 | One-cycle pulse on alarm match |

## Verification
The assertions rely on some input conditions. `tick` is a single-cycle strobe. Fields hold values that are legal for the current modes. The mode inputs do not change between loading a time and the strobe that advances it. The bench loads every field with a legal coded value before each scenario. It changes `bin_mode` and `hour24` only while no strobe is pending. It drives all inputs on the falling edge, so every strobe and write is seen at exactly one rising edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int TK_W = 8;

    localparam int IX_SEC  = 0;
    localparam int IX_ASEC = 1;
    localparam int IX_MIN  = 2;
    localparam int IX_AMIN = 3;
    localparam int IX_HR   = 4;
    localparam int IX_AHR  = 5;
    localparam int IX_DOW  = 6;
    localparam int IX_DOM  = 7;
    localparam int IX_MON  = 8;
    localparam int IX_YR   = 9;

    localparam logic [6:0] SEC_TOP  = 7'd59;
    localparam logic [6:0] HR_TOP   = 7'd23;
    localparam logic [6:0] DOW_TOP  = 7'd7;
    localparam logic [6:0] MON_TOP  = 7'd12;
    localparam logic [6:0] YR_TOP   = 7'd99;

    typedef logic [TK_W-1:0] tk_byte_t;

    typedef struct packed {
        tk_byte_t sec;
        tk_byte_t min;
        tk_byte_t hr;
        tk_byte_t dow;
        tk_byte_t dom;
        tk_byte_t mon;
        tk_byte_t yr;
    } tk_time_t;

    typedef struct packed {
        logic     cy;
        tk_byte_t val;
    } tk_step_t;

    // coded byte -> binary value
    function automatic logic [6:0] tk_dec(input tk_byte_t e, input logic bin);
        if (bin) return e[6:0];
        return 7'(e[7:4]) * 7'd10 + 7'(e[3:0]);
    endfunction

    // binary value -> coded byte
    function automatic tk_byte_t tk_enc(input logic [6:0] v, input logic bin);
        logic [6:0] tens, ones;
        if (bin) return {1'b0, v};
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // add one in the coded domain
    function automatic tk_byte_t tk_bump(input tk_byte_t e, input logic bin);
        if (bin || e[3:0] < 4'd9) return e + 8'd1;
        return {e[7:4] + 4'd1, 4'h0};
    endfunction

    // advance with wrap from top back to low
    function automatic tk_step_t tk_step(input tk_byte_t e, input logic [6:0] lo,
                                         input logic [6:0] hi, input logic bin);
        tk_step_t r;
        if (tk_dec(e, bin) >= hi) begin
            r.cy  = 1'b1;
            r.val = tk_enc(lo, bin);
        end else begin
            r.cy  = 1'b0;
            r.val = tk_bump(e, bin);
        end
        return r;
    endfunction

    function automatic logic [6:0] tk_mdays(input logic [6:0] m, input logic leap);
        case (m)
            7'd2:                      return leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_next_time.sv
module rtc_next_time
    import rtc_pkg::*;
(
    input  tk_time_t cur,
    input  logic     bin_mode,
    input  logic     hour24,
    output tk_time_t nxt
);
    tk_step_t s_sec, s_min, s_hr24, s_dow, s_dom, s_mon, s_yr;
    tk_byte_t hr12_next;
    logic     hr12_cy;
    logic     c_sec, c_min, c_hr, c_dom, c_mon;
    logic [6:0] h12, mon_b, yr_b;
    logic     leap;

    assign mon_b = tk_dec(cur.mon, bin_mode);
    assign yr_b  = tk_dec(cur.yr, bin_mode);
    assign leap  = (yr_b[1:0] == 2'b00);
    assign h12   = tk_dec({1'b0, cur.hr[6:0]}, bin_mode);

    always_comb begin
        s_sec  = tk_step(cur.sec, 7'd0, SEC_TOP, bin_mode);
        s_min  = tk_step(cur.min, 7'd0, SEC_TOP, bin_mode);
        s_hr24 = tk_step(cur.hr,  7'd0, HR_TOP,  bin_mode);
        s_dow  = tk_step(cur.dow, 7'd1, DOW_TOP, bin_mode);
        s_dom  = tk_step(cur.dom, 7'd1, tk_mdays(mon_b, leap), bin_mode);
        s_mon  = tk_step(cur.mon, 7'd1, MON_TOP, bin_mode);
        s_yr   = tk_step(cur.yr,  7'd0, YR_TOP,  bin_mode);
    end

    // 12-hour sequence: 11 -> 12 flips the afternoon bit, 12 -> 1 keeps it
    always_comb begin
        if (h12 == 7'd11) begin
            hr12_next = {~cur.hr[7], tk_enc(7'd12, bin_mode)[6:0]};
            hr12_cy   = cur.hr[7];
        end else if (h12 >= 7'd12) begin
            hr12_next = {cur.hr[7], tk_enc(7'd1, bin_mode)[6:0]};
            hr12_cy   = 1'b0;
        end else begin
            hr12_next = {cur.hr[7], tk_bump({1'b0, cur.hr[6:0]}, bin_mode)[6:0]};
            hr12_cy   = 1'b0;
        end
    end

    assign c_sec = s_sec.cy;
    assign c_min = c_sec & s_min.cy;
    assign c_hr  = c_min & (hour24 ? s_hr24.cy : hr12_cy);
    assign c_dom = c_hr  & s_dom.cy;
    assign c_mon = c_dom & s_mon.cy;

    always_comb begin
        nxt.sec = s_sec.val;
        nxt.min = c_sec ? s_min.val : cur.min;
        nxt.hr  = c_min ? (hour24 ? s_hr24.val : hr12_next) : cur.hr;
        nxt.dow = c_hr  ? s_dow.val : cur.dow;
        nxt.dom = c_hr  ? s_dom.val : cur.dom;
        nxt.mon = c_dom ? s_mon.val : cur.mon;
        nxt.yr  = c_mon ? s_yr.val  : cur.yr;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter int NFIELD = 3
) (
    input  logic [NFIELD-1:0][TK_W-1:0] alarm,
    input  logic [NFIELD-1:0][TK_W-1:0] value,
    output logic                        hit
);
    logic [NFIELD-1:0] fhit;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        assign fhit[i] = (alarm[i][TK_W-1 -: 2] == 2'b11) || (alarm[i] == value[i]);
    end

    assign hit = &fhit;
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              set_hold,
    input  logic              bin_mode,
    input  logic              hour24,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TK_W-1:0]   wdata,
    output logic [TK_W-1:0]   rdata,
    output logic              upd_evt,
    output logic              alm_evt
);
    tk_time_t time_q, time_nxt;
    tk_byte_t al_sec, al_min, al_hr;
    logic     adv, alarm_hit;

    assign adv = tick & ~set_hold & ~wr_en;

    rtc_next_time u_next (
        .cur      (time_q),
        .bin_mode (bin_mode),
        .hour24   (hour24),
        .nxt      (time_nxt)
    );

    rtc_alarm_match #(.NFIELD(3)) u_alarm (
        .alarm ({al_hr, al_min, al_sec}),
        .value ({time_nxt.hr, time_nxt.min, time_nxt.sec}),
        .hit   (alarm_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q  <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                         dom: 8'h01, mon: 8'h01, yr: 8'h00};
            al_sec  <= '0;
            al_min  <= '0;
            al_hr   <= '0;
            upd_evt <= 1'b0;
            alm_evt <= 1'b0;
        end else begin
            upd_evt <= adv;
            alm_evt <= adv & alarm_hit;
            if (wr_en) begin
                case (int'(addr))
                    IX_SEC:  time_q.sec <= wdata;
                    IX_ASEC: al_sec     <= wdata;
                    IX_MIN:  time_q.min <= wdata;
                    IX_AMIN: al_min     <= wdata;
                    IX_HR:   time_q.hr  <= wdata;
                    IX_AHR:  al_hr      <= wdata;
                    IX_DOW:  time_q.dow <= wdata;
                    IX_DOM:  time_q.dom <= wdata;
                    IX_MON:  time_q.mon <= wdata;
                    IX_YR:   time_q.yr  <= wdata;
                    default: ;
                endcase
            end else if (adv) begin
                time_q <= time_nxt;
            end
        end
    end

    always_comb begin
        case (int'(addr))
            IX_SEC:  rdata = time_q.sec;
            IX_ASEC: rdata = al_sec;
            IX_MIN:  rdata = time_q.min;
            IX_AMIN: rdata = al_min;
            IX_HR:   rdata = time_q.hr;
            IX_AHR:  rdata = al_hr;
            IX_DOW:  rdata = time_q.dow;
            IX_DOM:  rdata = time_q.dom;
            IX_MON:  rdata = time_q.mon;
            IX_YR:   rdata = time_q.yr;
            default: rdata = '0;
        endcase
    end

    // R9
    upd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        upd_evt |-> ($past(tick) && !$past(set_hold) && !$past(wr_en)));

    // R3
    sec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(time_q.sec));

    // R10
    sec_moves_chk: assert property (@(posedge clk) disable iff (rst)
        upd_evt |-> (time_q.sec != $past(time_q.sec)));

    // R11
    alm_with_upd_chk: assert property (@(posedge clk) disable iff (rst)
        alm_evt |-> upd_evt);

    // R7
    dom_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_evt && $past(time_q.dom) != 8'h00) |-> (time_q.dom != 8'h00));
endmodule

// File: tb/test_rtc_timekeeper.sv
module test_rtc_timekeeper;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, set_hold = 1'b0, bin_mode = 1'b0, hour24 = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       upd_evt, alm_evt;
    int         total = 0, bad = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    rtc_timekeeper #(.ADDR_W(4)) i_rtc_timekeeper (
        .clk(clk), .rst(rst), .tick(tick), .set_hold(set_hold),
        .bin_mode(bin_mode), .hour24(hour24), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .upd_evt(upd_evt), .alm_evt(alm_evt)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        addr = 4'(a);
        #1 d = rdata;
    endtask

    task automatic rdchk(input string req, input int a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, $sformatf("reg%0d", a), d, exp);
    endtask

    // strobe for one cycle; on return the registered results are visible
    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(4, h); wr(2, m); wr(0, s);
    endtask

    task automatic t_reset();
        logic [7:0] exp [10] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        chk("R1", "upd_evt", {7'd0, upd_evt}, 8'h00);
        chk("R1", "alm_evt", {7'd0, alm_evt}, 8'h00);
        for (int i = 0; i < 10; i++) rdchk("R1", i, exp[i]);
    endtask

    task automatic t_regs();
        for (int i = 0; i < 10; i++) wr(i, 8'(8'h10 + i));
        for (int i = 0; i < 10; i++) rdchk("R2", i, 8'(8'h10 + i));
        wr(12, 8'h5A);
        rdchk("R2", 12, 8'h00);
        for (int i = 0; i < 10; i++) rdchk("R2", i, 8'(8'h10 + i));
    endtask

    task automatic t_bcd();
        bin_mode = 1'b0; hour24 = 1'b1;
        load(8'h05, 8'h20, 8'h09);
        pulse();
        chk("R10", "upd pulse", {7'd0, upd_evt}, 8'h01);
        rdchk("R3", 0, 8'h10);
        chk("R10", "upd single", {7'd0, upd_evt}, 8'h00);
        load(8'h05, 8'h59, 8'h59);
        pulse();
        rdchk("R3", 0, 8'h00);
        rdchk("R3", 2, 8'h00);
        rdchk("R3", 4, 8'h06);
    endtask

    task automatic t_bin();
        bin_mode = 1'b1; hour24 = 1'b1;
        load(8'd3, 8'd10, 8'd9);
        pulse();
        rdchk("R4", 0, 8'h0A);
        load(8'd3, 8'd10, 8'd59);
        pulse();
        rdchk("R4", 0, 8'd0);
        rdchk("R4", 2, 8'd11);
        bin_mode = 1'b0;
    endtask

    task automatic t_h24();
        hour24 = 1'b1;
        wr(6, 8'h03); wr(7, 8'h05); wr(8, 8'h06);
        load(8'h23, 8'h59, 8'h59);
        pulse();
        rdchk("R5", 4, 8'h00);
        rdchk("R5", 7, 8'h06);
        rdchk("R8", 6, 8'h04);
    endtask

    task automatic t_h12();
        hour24 = 1'b0;
        wr(7, 8'h10);
        load(8'h11, 8'h59, 8'h59);
        pulse();
        rdchk("R6", 4, 8'h92);
        rdchk("R6", 7, 8'h10);
        load(8'h92, 8'h59, 8'h59);
        pulse();
        rdchk("R6", 4, 8'h81);
        load(8'h12, 8'h59, 8'h59);
        pulse();
        rdchk("R6", 4, 8'h01);
        load(8'h91, 8'h59, 8'h59);
        pulse();
        rdchk("R6", 4, 8'h12);
        rdchk("R6", 7, 8'h11);
        hour24 = 1'b1;
    endtask

    task automatic date_case(input string req, input logic [7:0] y, input logic [7:0] mo,
                             input logic [7:0] d, input logic [7:0] ey,
                             input logic [7:0] emo, input logic [7:0] ed);
        wr(9, y); wr(8, mo); wr(7, d);
        load(8'h23, 8'h59, 8'h59);
        pulse();
        rdchk(req, 7, ed);
        rdchk(req, 8, emo);
        rdchk(req, 9, ey);
    endtask

    task automatic t_cal();
        hour24 = 1'b1; bin_mode = 1'b0;
        date_case("R7", 8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
        date_case("R7", 8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
        date_case("R7", 8'h24, 8'h04, 8'h30, 8'h24, 8'h05, 8'h01);
        date_case("R7", 8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
        wr(6, 8'h07);
        load(8'h23, 8'h59, 8'h59);
        pulse();
        rdchk("R8", 6, 8'h01);
    endtask

    task automatic t_hold();
        load(8'h01, 8'h02, 8'h05);
        @(negedge clk) set_hold = 1'b1;
        pulse();
        chk("R9", "upd_evt held", {7'd0, upd_evt}, 8'h00);
        rdchk("R9", 0, 8'h05);
        @(negedge clk) set_hold = 1'b0;
    endtask

    task automatic t_alarm();
        wr(1, 8'h31); wr(3, 8'h10); wr(5, 8'h08);
        load(8'h08, 8'h10, 8'h30);
        pulse();
        chk("R11", "exact match", {7'd0, alm_evt}, 8'h01);
        pulse();
        chk("R11", "no match", {7'd0, alm_evt}, 8'h00);
        wr(1, 8'hC0); wr(3, 8'hFF);
        load(8'h08, 8'h10, 8'h40);
        pulse();
        chk("R11", "wildcard", {7'd0, alm_evt}, 8'h01);
        wr(5, 8'h09);
        pulse();
        chk("R11", "hour mismatch", {7'd0, alm_evt}, 8'h00);
    endtask

    task automatic t_collide();
        wr(1, 8'hC0); wr(3, 8'hC0); wr(5, 8'hC0);
        wr(0, 8'h20);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 4'd0; wdata = 8'h44;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R12", "upd_evt", {7'd0, upd_evt}, 8'h00);
        chk("R12", "alm_evt", {7'd0, alm_evt}, 8'h00);
        rdchk("R12", 0, 8'h44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_bcd();
        t_bin();
        t_h24();
        t_h12();
        t_cal();
        t_hold();
        t_alarm();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule